// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital half of a dual-slope integrating analog-to-digital converter. It closes the analog switches of an external buffer, integrator and comparator in a fixed order. First comes an auto-zero phase. Next is a signal-integrate phase of fixed length. Last is a reference-deintegrate phase that ends when the integrator returns to its zero level. The length of the deintegrate phase, counted in clocks, is the reading. That count is kept in a five-digit decimal (BCD) counter. It is published together with a polarity bit, a busy output and over-range and under-range flags.

A mode input selects full resolution or a reduced resolution. Full resolution uses a full-scale count of `2*SIG_COUNTS` (20,000 by default). Reduced resolution divides every phase length by ten, holds the lowest decade at zero and feeds the count into the second decade. A run input either lets the converter free-run, or holds the last reading and starts one new conversion on each rising edge. The comparator is sampled by a register once per clock. Because of that register delay, the sequencer inhibits counting for one clock at the start of deintegrate. The reading is therefore not one count high.

Top module: `dual_slope_seq`

## Requirements
- R1: While reset is high and right after it, auto-zero is the only switch enable on, and busy, polarity, over-range, under-range and the result are all 0. The first auto-zero after reset lasts S+1 clocks, where S is the signal-integrate length of the selected mode.
- R2: Signal integrate lasts exactly S clocks. With run held high, successive starts of signal integrate are 4*S+2 clocks apart, whatever the reading. Auto-zero absorbs the deintegrate time that was not used.
- R3: Exactly one of the four switch enables (auto-zero, signal, plus-reference, minus-reference) is high in every cycle. During deintegrate, polarity 1 selects minus-reference and polarity 0 selects plus-reference. When busy falls, auto-zero is on.
- R4: If the comparator flips n clocks after deintegrate starts, with n < 2*S, the reading is n. The first deintegrate clock is never counted.
- R5: Busy rises with signal integrate. It falls on the second clock edge after the comparator input flips, so deintegrate lasts n+2 clocks.
- R6: If no crossing is seen within 2*S+1 deintegrate clocks, busy falls, over-range sets, and the reading is full scale, 2*S. By default this is BCD 2_0000, so the four lower digits show 0000.
- R7: Polarity is the registered comparator level at the end of signal integrate, with 1 meaning the comparator was high. It is valid from the first deintegrate clock, including for a zero reading, and it does not change until the next deintegrate.
- R8: The result output changes only on the clock edge one cycle after busy falls, and it keeps its value at all other times.
- R9: Over-range stays set through the following auto-zero and signal integrate. It clears on the edge that starts the next deintegrate.
- R10: Under-range sets when busy falls if the reading is at most 9% of full scale: n <= 1800 by default, n <= 180 in reduced mode. It clears on the edge that starts the next signal integrate.
- R11: When mode_full_i is 0, S is SIG_COUNTS/10 and digit 0 (bits 3:0) is held at 0. Each count adds one to digit 1, so the result reads 10*n. The mode is taken only while the converter is not busy.
- R12: The run input passes through two synchroniser flops. When it is low at the end of auto-zero, the converter stays in auto-zero and holds its result. A rising edge then starts signal integrate within four clocks. A pulse that arrives while a conversion is in progress is ignored.
- R13: result_o nibble i holds decimal digit i, with digit 0 least significant. Every nibble stays in the range 0 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_full_i | input | 1 | 1 = full resolution, 0 = reduced (phases /10, low decade cleared) |
| run_i | input | 1 | Asynchronous run/hold request, high = free-run |
| cmp_i | input | 1 | Comparator level, sampled every clock |
| az_sw_o | output | 1 | Auto-zero switch enable |
| sig_sw_o | output | 1 | Signal-input switch enable |
| refp_sw_o | output | 1 | Plus-reference switch enable (polarity 0) |
| refm_sw_o | output | 1 | Minus-reference switch enable (polarity 1) |
| busy_o | output | 1 | High through signal integrate and deintegrate |
| pol_o | output | 1 | Latched input polarity |
| over_o | output | 1 | Over-range flag |
| under_o | output | 1 | Under-range flag |
| result_o | output | 4*NDIG | Latched BCD reading |

## Verification
The bench uses a scaled-down configuration and sweeps the crossing point across every count of the reduced range, including both sides of full scale. It also checks a set of full-mode points on each side of the under-range threshold. Several errors would show up as readings one count off at every point: a missing count inhibit, a wrong sample register, or an off-by-one in the overload window. A design that sets and clears the two flags at the same phase boundary fails the persistence checks made at the next signal-integrate start. A design that does not fill the cycle with auto-zero after an early crossing shows a period that depends on the reading. A design that accepts a run pulse mid-conversion starts an extra conversion during the hold window that follows.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic [1:0] {
    PH_AZ    = 2'd0,
    PH_SIG   = 2'd1,
    PH_DEINT = 2'd2,
    PH_HOLD  = 2'd3
  } phase_t;
endpackage

// File: rtl/dsc_run_sync.sv
module dsc_run_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], async_i};
  end

  assign level_o = sh[STAGES-1];
  assign rise_o  = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/dsc_bcd_counter.sv
module dsc_bcd_counter #(
  parameter int NDIG = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr_i,
  input  logic            inc_i,
  input  logic            coarse_i,
  output logic [4*NDIG-1:0] value_o,
  output logic            carry_o
);
  logic [NDIG:0] cy;

  assign cy[0]   = inc_i & ~coarse_i;
  assign carry_o = cy[NDIG];

  for (genvar d = 0; d < NDIG; d++) begin : g_dig
    logic [3:0] q;
    logic       cin;

    if (d == 1) begin : g_feed
      assign cin = coarse_i ? inc_i : cy[1];
    end else begin : g_chain
      assign cin = cy[d];
    end

    assign cy[d+1] = (d == 0) ? (cy[0] & (q == 4'd9)) : (cin & (q == 4'd9));

    if (d == 0) begin : g_low
      always_ff @(posedge clk) begin
        if (rst || clr_i || coarse_i) q <= 4'd0;
        else if (cin)                 q <= (q == 4'd9) ? 4'd0 : q + 4'd1;
      end
      AST_LOW_DECADE_ZERO: assert property (@(posedge clk) disable iff (rst)
        coarse_i |=> (q == 4'd0)); // R11
    end else begin : g_high
      always_ff @(posedge clk) begin
        if (rst || clr_i) q <= 4'd0;
        else if (cin)     q <= (q == 4'd9) ? 4'd0 : q + 4'd1;
      end
    end

    assign value_o[4*d +: 4] = q;

    AST_DIGIT_DECIMAL: assert property (@(posedge clk) disable iff (rst)
      q <= 4'd9); // R13
  end
endmodule

// File: rtl/dsc_phase_ctrl.sv
module dsc_phase_ctrl
  import dsc_pkg::*;
#(
  parameter int SIG_COUNTS = 10000,
  parameter int COARSE_DIV = 10,
  parameter int PCW        = 17
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_i,
  input  logic run_lvl_i,
  input  logic run_rise_i,
  input  logic cmp_q_i,
  output logic mode_q_o,
  output logic pol_o,
  output logic az_sw_o,
  output logic sig_sw_o,
  output logic refp_sw_o,
  output logic refm_sw_o,
  output logic busy_o,
  output logic sig_start_o,
  output logic deint_start_o,
  output logic end_o,
  output logic ovl_o,
  output logic under_hit_o,
  output logic cnt_en_o
);
  localparam int SIG_R = SIG_COUNTS / COARSE_DIV;
  localparam logic [PCW-1:0] LEN_F = PCW'(SIG_COUNTS);
  localparam logic [PCW-1:0] LEN_R = PCW'(SIG_R);
  localparam logic [PCW-1:0] UR_F  = PCW'((SIG_COUNTS * 9) / 50);
  localparam logic [PCW-1:0] UR_R  = PCW'((SIG_R * 9) / 50);
  localparam logic [PCW-1:0] ONE   = PCW'(1);
  localparam logic [PCW-1:0] TWO   = PCW'(2);

  phase_t         ph;
  logic [PCW-1:0] pc;
  logic           mode_q;
  logic           pol_q;

  logic [PCW-1:0] sig_len, az_len, dm_len, ur_lim;
  logic           xing, last_sig, dm_last, end_norm, end_ovl, az_done, go_sig;

  always_comb begin
    sig_len  = mode_q ? LEN_F : LEN_R;
    az_len   = sig_len + ONE;
    dm_len   = (sig_len << 1) + ONE;
    ur_lim   = mode_q ? UR_F : UR_R;
    xing     = (ph == PH_DEINT) && (cmp_q_i != pol_q);
    last_sig = (ph == PH_SIG) && (pc == sig_len - ONE);
    dm_last  = (ph == PH_DEINT) && (pc == (sig_len << 1));
    end_norm = xing;
    end_ovl  = dm_last && !xing;
    az_done  = (ph == PH_AZ) && (pc == '0);
    go_sig   = (az_done && run_lvl_i) || ((ph == PH_HOLD) && run_rise_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= PH_AZ;
      pc     <= LEN_F;
      mode_q <= 1'b1;
      pol_q  <= 1'b0;
    end else begin
      if (ph == PH_AZ || ph == PH_HOLD) mode_q <= mode_i;
      unique case (ph)
        PH_AZ: begin
          if (!az_done)       pc <= pc - ONE;
          else if (run_lvl_i) begin ph <= PH_SIG; pc <= '0; end
          else                ph <= PH_HOLD;
        end
        PH_HOLD: begin
          if (run_rise_i) begin ph <= PH_SIG; pc <= '0; end
        end
        PH_SIG: begin
          if (last_sig) begin
            ph    <= PH_DEINT;
            pc    <= '0;
            pol_q <= cmp_q_i;
          end else begin
            pc <= pc + ONE;
          end
        end
        PH_DEINT: begin
          if (end_norm) begin
            ph <= PH_AZ;
            pc <= az_len + dm_len - pc - TWO;
          end else if (end_ovl) begin
            ph <= PH_AZ;
            pc <= az_len - ONE;
          end else begin
            pc <= pc + ONE;
          end
        end
        default: ph <= PH_AZ;
      endcase
    end
  end

  assign mode_q_o      = mode_q;
  assign pol_o         = pol_q;
  assign az_sw_o       = (ph == PH_AZ) || (ph == PH_HOLD);
  assign sig_sw_o      = (ph == PH_SIG);
  assign refp_sw_o     = (ph == PH_DEINT) && !pol_q;
  assign refm_sw_o     = (ph == PH_DEINT) && pol_q;
  assign busy_o        = (ph == PH_SIG) || (ph == PH_DEINT);
  assign sig_start_o   = go_sig;
  assign deint_start_o = last_sig;
  assign end_o         = end_norm || end_ovl;
  assign ovl_o         = end_ovl;
  assign under_hit_o   = end_norm && (pc <= ur_lim + ONE);
  assign cnt_en_o      = (ph == PH_DEINT) && (pc != '0) && !xing;

  AST_ONE_SWITCH: assert property (@(posedge clk) disable iff (rst)
    $countones({az_sw_o, sig_sw_o, refp_sw_o, refm_sw_o}) == 1); // R3
  AST_BUSY_AT_SIG: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> sig_sw_o); // R5
  AST_POL_STEADY: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_DEINT && $past(ph) == PH_DEINT) |-> $stable(pol_q)); // R7
  AST_DEINT_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_DEINT) |-> (pc <= (sig_len << 1))); // R6
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_HOLD && !run_rise_i) |=> (ph == PH_HOLD)); // R12
endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq #(
  parameter int SIG_COUNTS  = 10000,
  parameter int COARSE_DIV  = 10,
  parameter int NDIG        = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_full_i,
  input  logic              run_i,
  input  logic              cmp_i,
  output logic              az_sw_o,
  output logic              sig_sw_o,
  output logic              refp_sw_o,
  output logic              refm_sw_o,
  output logic              busy_o,
  output logic              pol_o,
  output logic              over_o,
  output logic              under_o,
  output logic [4*NDIG-1:0] result_o
);
  localparam int PCW = $clog2(3 * SIG_COUNTS + 4) + 1;

  logic cmp_q, run_lvl, run_rise, mode_q;
  logic sig_start, deint_start, conv_end, ovl, under_hit, cnt_en;
  logic bcd_carry, carry_seen, load_q, over_q, under_q;
  logic [4*NDIG-1:0] bcd_val, result_q;

  always_ff @(posedge clk) begin
    if (rst) cmp_q <= 1'b0;
    else     cmp_q <= cmp_i;
  end

  dsc_run_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (run_i),
    .level_o (run_lvl),
    .rise_o  (run_rise)
  );

  dsc_phase_ctrl #(
    .SIG_COUNTS (SIG_COUNTS),
    .COARSE_DIV (COARSE_DIV),
    .PCW        (PCW)
  ) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .mode_i        (mode_full_i),
    .run_lvl_i     (run_lvl),
    .run_rise_i    (run_rise),
    .cmp_q_i       (cmp_q),
    .mode_q_o      (mode_q),
    .pol_o         (pol_o),
    .az_sw_o       (az_sw_o),
    .sig_sw_o      (sig_sw_o),
    .refp_sw_o     (refp_sw_o),
    .refm_sw_o     (refm_sw_o),
    .busy_o        (busy_o),
    .sig_start_o   (sig_start),
    .deint_start_o (deint_start),
    .end_o         (conv_end),
    .ovl_o         (ovl),
    .under_hit_o   (under_hit),
    .cnt_en_o      (cnt_en)
  );

  dsc_bcd_counter #(.NDIG(NDIG)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .clr_i    (deint_start),
    .inc_i    (cnt_en),
    .coarse_i (~mode_q),
    .value_o  (bcd_val),
    .carry_o  (bcd_carry)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      carry_seen <= 1'b0;
      load_q     <= 1'b0;
      result_q   <= '0;
      over_q     <= 1'b0;
      under_q    <= 1'b0;
    end else begin
      load_q <= conv_end;
      if (load_q) result_q <= bcd_val;

      if (deint_start)    carry_seen <= 1'b0;
      else if (bcd_carry) carry_seen <= 1'b1;

      if (deint_start)                             over_q <= 1'b0;
      else if (conv_end && (ovl || carry_seen))    over_q <= 1'b1;

      if (sig_start)      under_q <= 1'b0;
      else if (under_hit) under_q <= 1'b1;
    end
  end

  assign result_o = result_q;
  assign over_o   = over_q;
  assign under_o  = under_q;

  AST_RESULT_STILL: assert property (@(posedge clk) disable iff (rst)
    !$past(load_q) |-> $stable(result_q)); // R8
  AST_OVER_CLEARED: assert property (@(posedge clk) disable iff (rst)
    $rose(refp_sw_o | refm_sw_o) |-> !over_q); // R9
  AST_UNDER_CLEARED: assert property (@(posedge clk) disable iff (rst)
    $rose(sig_sw_o) |-> !under_q); // R10
  AST_FLAGS_APART: assert property (@(posedge clk) disable iff (rst)
    !(over_q && under_q)); // R6
endmodule

// File: tb/dual_slope_seq_test.sv
module dual_slope_seq_test;
  localparam int S = 1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_full_i = 1'b1;
  logic run_i = 1'b1;
  logic cmp_i = 1'b0;
  logic az_sw_o, sig_sw_o, refp_sw_o, refm_sw_o, busy_o, pol_o, over_o, under_o;
  logic [19:0] result_o;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int last_int = 0;
  bit md = 1'b1;
  bit prev_over = 1'b0;
  logic [19:0] prev_res = '0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dual_slope_seq #(.SIG_COUNTS(S), .COARSE_DIV(10), .NDIG(5), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .mode_full_i(mode_full_i), .run_i(run_i), .cmp_i(cmp_i),
    .az_sw_o(az_sw_o), .sig_sw_o(sig_sw_o), .refp_sw_o(refp_sw_o), .refm_sw_o(refm_sw_o),
    .busy_o(busy_o), .pol_o(pol_o), .over_o(over_o), .under_o(under_o), .result_o(result_o)
  );

  function automatic logic [19:0] to_bcd(input int v);
    logic [19:0] r;
    int t = v;
    for (int i = 0; i < 5; i++) begin
      r[4*i +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic measure(input int n, input bit sgn, input bit chk_per, input bit chk_len);
    int seff = md ? S : S / 10;
    int ur = (seff * 9) / 50;
    bit ovl = (n >= 2 * seff);
    int val = ovl ? 2 * seff : n;
    logic [19:0] exp_bcd = to_bcd(md ? val : val * 10);
    bit exp_under = !ovl && (n <= ur);
    int exp_k = ovl ? 2 * seff + 1 : n + 2;
    int t0;
    int k;
    cmp_i = sgn;
    while (!sig_sw_o) @(negedge clk);
    t0 = cyc;
    if (chk_per) chk(t0 - last_int == 4 * seff + 2, "R2 cycle period", t0 - last_int, 4 * seff + 2);
    last_int = t0;
    chk(under_o == 1'b0, "R10 under clear in integrate", under_o, 0);
    chk(over_o == prev_over, "R9 over persists to deintegrate", over_o, prev_over);
    chk(busy_o == 1'b1, "R5 busy in integrate", busy_o, 1);
    while (!(refp_sw_o || refm_sw_o)) @(negedge clk);
    if (chk_len) chk(cyc - t0 == seff, "R2 integrate length", cyc - t0, seff);
    chk(over_o == 1'b0, "R9 over cleared at deintegrate", over_o, 0);
    chk(pol_o == sgn, "R7 polarity", pol_o, sgn);
    chk(sgn ? (refm_sw_o && !refp_sw_o && !az_sw_o && !sig_sw_o)
            : (refp_sw_o && !refm_sw_o && !az_sw_o && !sig_sw_o),
        "R3 reference switch", {refm_sw_o, refp_sw_o}, sgn ? 2 : 1);
    k = 0;
    cmp_i = (n <= 0) ? ~sgn : sgn;
    forever begin
      @(negedge clk);
      k++;
      if (!busy_o) break;
      cmp_i = (k >= n) ? ~sgn : sgn;
    end
    chk(k == exp_k, ovl ? "R6 overload window" : "R5 busy fall", k, exp_k);
    chk(over_o == ovl, "R6 over flag", over_o, ovl);
    chk(under_o == exp_under, "R10 under flag", under_o, exp_under);
    chk(pol_o == sgn, "R7 polarity held", pol_o, sgn);
    chk(az_sw_o == 1'b1, "R3 back to auto-zero", az_sw_o, 1);
    chk(result_o == prev_res, "R8 result held until load", result_o, prev_res);
    @(negedge clk);
    chk(result_o == exp_bcd, md ? "R4 reading" : "R11 reduced reading", result_o, exp_bcd);
    prev_res = exp_bcd;
    prev_over = ovl;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int t;
    int bad;
    int fl[8] = '{0, 1, 180, 181, 777, 1999, 2000, 2500};
    repeat (5) @(negedge clk);
    chk(az_sw_o && !sig_sw_o && !refp_sw_o && !refm_sw_o, "R1 reset switches",
        {az_sw_o, sig_sw_o, refp_sw_o, refm_sw_o}, 8);
    chk(!busy_o && !pol_o && !over_o && !under_o, "R1 reset flags",
        {busy_o, pol_o, over_o, under_o}, 0);
    chk(result_o == '0, "R1 reset result", result_o, 0);
    rst = 1'b0;
    t = 0;
    do begin
      @(negedge clk);
      t++;
    end while (!sig_sw_o && t < 5000);
    chk(t == S + 1, "R1 first auto-zero length", t, S + 1);

    for (int i = 0; i < 8; i++)
      measure(fl[i], 1'(i % 2), i != 0, 1'b1);

    md = 1'b0;
    mode_full_i = 1'b0;
    measure(5, 1'b1, 1'b0, 1'b1);
    for (int n = 0; n <= 201; n++)
      measure(n, 1'(n % 2), 1'b1, 1'b1);

    run_i = 1'b0;
    bad = 0;
    repeat (1200) begin
      @(negedge clk);
      if (sig_sw_o || busy_o || !az_sw_o) bad++;
    end
    chk(bad == 0, "R12 held in auto-zero", bad, 0);
    chk(result_o == prev_res, "R12 reading held", result_o, prev_res);

    cmp_i = 1'b0;
    run_i = 1'b1;
    t = 0;
    do begin
      @(negedge clk);
      t++;
      if (t == 3) run_i = 1'b0;
    end while (!sig_sw_o && t < 20);
    run_i = 1'b0;
    chk(t <= 4, "R12 pulse starts conversion", t, 4);
    repeat (10) @(negedge clk);
    run_i = 1'b1;
    repeat (3) @(negedge clk);
    run_i = 1'b0;
    measure(37, 1'b0, 1'b0, 1'b0);
    bad = 0;
    repeat (1200) begin
      @(negedge clk);
      if (sig_sw_o || busy_o) bad++;
    end
    chk(bad == 0, "R12 mid-cycle pulse ignored", bad, 0);
    summary();
  end
endmodule